// File: doc/BRIEF.md
# Region-Decoded Wait-State Bus Controller

This block sits between a CPU data port and the on-chip memory and peripheral bus. Each CPU request is classified by address into one region: fast RAM, a peripheral frame, flash, one-time-programmable memory, the flash password words, boot ROM, or unmapped space. The block then drives the downstream bus for exactly as many cycles as that region and access kind require. Some regions have fixed timing. Some let a peripheral stretch the access through a ready input. Flash and OTP take their wait counts from configuration inputs, and values below the legal floor are raised to it.

Two ordering rules add dead cycles before the bus phase. The first applies when a write to a protected peripheral frame is followed by a read of a different location in a protected frame: the read waits a fixed number of alignment cycles, unless the ordering guard is switched off. The second applies to two writes in a row to the first slow peripheral frame: the second write waits one cycle. The CPU sees a single stall output and a one-cycle completion strobe. Only one access is in flight at a time.

Top module: `wsbus_ctrl`

## Requirements
- R1: Accesses to RAM (0x000000–0x0007FF, 0x008000–0x013FFF), fast peripheral frame (0x000800–0x000FFF) and boot ROM (0x3F8000–0x3FFFFF) take one bus cycle. The completion strobe is high in the first cycle after the accepting edge.
- R2: Slow peripheral frames A (0x006000–0x006FFF), B (0x007000–0x007FFF) and C (0x005000–0x005FFF) complete writes with zero wait states and reads with two wait states.
- R3: Frames A and C do not complete while `mem_ready` is low, even after their base count has expired. Frame B completes on its base count whatever `mem_ready` does.
- R4: A write to frame A whose previous access was also a write to frame A gets one idle cycle before its bus phase. Writes to any other region never pay this cycle.
- R5: Flash (0x3D8000–0x3F7FF7) reads use the paged count when the previous access was flash in the same 8-word page (same address bits above bit 2), and the random count otherwise.
- R6: The paged flash count is used as programmed, with zero allowed. The random count is raised to at least 1 and to at least the paged count. The OTP count is raised to at least 1.
- R7: OTP (0x3D7800–0x3D7BFF) uses its configured count. The password words (0x3F7FF8–0x3F7FFF) always use 16 wait states.
- R8: With `cfg_order_en` high, a read of a protected frame (A, B or C) at a different address right after a write to a protected frame gets PROT_CYC (default 2) idle cycles before its bus phase. The penalty is not paid when `cfg_order_en` is low or the address is the same.
- R9: An unmapped address completes in one cycle with `cpu_err` high and `cpu_rdata` zero, and never raises `mem_en`.
- R10: From acceptance until completion, `cpu_stall` is high and new requests are ignored. While `mem_en` is high, `mem_addr` and `mem_we` hold the accepted request's values.
- R11: Reset clears any access in flight and the access history. After reset `cpu_stall`, `cpu_done` and `mem_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Request, sampled while idle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 22 | Word address |
| cpu_wdata | input | 16 | Write data |
| cpu_stall | output | 1 | CPU must wait |
| cpu_done | output | 1 | Access completes this cycle |
| cpu_err | output | 1 | Completed access hit unmapped space |
| cpu_rdata | output | 16 | Read data, valid with cpu_done |
| cfg_flash_page_ws | input | 4 | Flash paged wait count |
| cfg_flash_rand_ws | input | 4 | Flash random wait count |
| cfg_otp_ws | input | 4 | OTP wait count |
| cfg_order_en | input | 1 | Write-then-read ordering guard enable |
| mem_en | output | 1 | Downstream bus phase active |
| mem_we | output | 1 | Downstream write |
| mem_addr | output | 22 | Downstream address |
| mem_wdata | output | 16 | Downstream write data |
| mem_rdata | input | 16 | Downstream read data |
| mem_ready | input | 1 | Peripheral ready for stretchable frames |

## Verification
Some properties are checked on every cycle. The downstream address and direction stay steady through a bus phase. Completion is always followed by a quiet cycle. Unmapped completions return zero and never touch the bus. A fixed frame never waits on a low ready. The computed counts respect the clamping floors and the fixed password count. Exact cycle totals need a sequence of accesses, because the history, the flash page and the ready timing all depend on what came before. Those totals are therefore shown only by the bench's ordered scenarios: the alignment penalty, the back-to-back write cycle, paged against random flash and ready stretching.

// File: rtl/wsbus_pkg.sv
package wsbus_pkg;
    localparam int ADDR_W   = 22;
    localparam int DATA_W   = 16;
    localparam int CFG_W    = 4;
    localparam int WS_W     = 5;
    localparam int PAGE_LSB = 3;
    localparam logic [WS_W-1:0] PF_RD_WS = WS_W'(2);
    localparam logic [WS_W-1:0] PWD_WS   = WS_W'(16);

    typedef enum logic [3:0] {
        RG_NONE, RG_RAM, RG_PF0, RG_PFA, RG_PFB, RG_PFC,
        RG_FLASH, RG_OTP, RG_PWD, RG_BOOT
    } region_e;

    typedef enum logic [1:0] {ST_IDLE, ST_ALIGN, ST_ACCESS} state_e;

    typedef struct packed {
        region_e             rg;
        logic                we;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdata;
    } acc_s;

    function automatic region_e decode(input logic [ADDR_W-1:0] a);
        if (a <= 22'h0007FF)                          return RG_RAM;
        else if (a <= 22'h000FFF)                     return RG_PF0;
        else if (a >= 22'h005000 && a <= 22'h005FFF)  return RG_PFC;
        else if (a >= 22'h006000 && a <= 22'h006FFF)  return RG_PFA;
        else if (a >= 22'h007000 && a <= 22'h007FFF)  return RG_PFB;
        else if (a >= 22'h008000 && a <= 22'h013FFF)  return RG_RAM;
        else if (a >= 22'h3D7800 && a <= 22'h3D7BFF)  return RG_OTP;
        else if (a >= 22'h3D8000 && a <= 22'h3F7FF7)  return RG_FLASH;
        else if (a >= 22'h3F7FF8 && a <= 22'h3F7FFF)  return RG_PWD;
        else if (a >= 22'h3F8000)                     return RG_BOOT;
        else                                          return RG_NONE;
    endfunction

    function automatic logic is_guarded(input region_e r);
        return (r == RG_PFA) || (r == RG_PFB) || (r == RG_PFC);
    endfunction

    function automatic logic is_stretchable(input region_e r);
        return (r == RG_PFA) || (r == RG_PFC);
    endfunction

    function automatic logic [WS_W-1:0] ws_max(input logic [WS_W-1:0] x,
                                               input logic [WS_W-1:0] y);
        return (x > y) ? x : y;
    endfunction
endpackage

// File: rtl/wsbus_timing.sv
module wsbus_timing
    import wsbus_pkg::*;
(
    input  region_e          rg,
    input  logic             we,
    input  logic             page_hit,
    input  logic [CFG_W-1:0] page_ws,
    input  logic [CFG_W-1:0] rand_ws,
    input  logic [CFG_W-1:0] otp_ws,
    output logic [WS_W-1:0]  waits
);
    logic [WS_W-1:0] pg_eff, rnd_eff, otp_eff;

    always_comb begin
        pg_eff  = WS_W'(page_ws);
        rnd_eff = ws_max(ws_max(WS_W'(rand_ws), WS_W'(1)), pg_eff);
        otp_eff = ws_max(WS_W'(otp_ws), WS_W'(1));
        case (rg)
            RG_PFA, RG_PFB, RG_PFC: waits = we ? '0 : PF_RD_WS;
            RG_FLASH:               waits = page_hit ? pg_eff : rnd_eff;
            RG_OTP:                 waits = otp_eff;
            RG_PWD:                 waits = PWD_WS;
            default:                waits = '0;
        endcase
    end

    always_comb begin
        // R6
        if (rg == RG_FLASH && !page_hit)
            rand_floor_chk: assert (waits >= WS_W'(1) && waits >= WS_W'(page_ws));
        // R6
        if (rg == RG_OTP)
            otp_floor_chk: assert (waits >= WS_W'(1));
        // R7
        if (rg == RG_PWD)
            pwd_fixed_chk: assert (waits == WS_W'(16));
        // R2
        if (is_guarded(rg) && we)
            pf_write_zero_chk: assert (waits == '0);
    end
endmodule

// File: rtl/wsbus_history.sv
module wsbus_history
    import wsbus_pkg::*;
#(
    parameter int PROT_CYC = 2,
    localparam int PRE_W   = $clog2(PROT_CYC + 1) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fin,
    input  region_e           fin_rg,
    input  logic              fin_we,
    input  logic [ADDR_W-1:0] fin_addr,
    input  region_e           nxt_rg,
    input  logic              nxt_we,
    input  logic [ADDR_W-1:0] nxt_addr,
    input  logic              order_en,
    output logic              page_hit,
    output logic [PRE_W-1:0]  pre_n
);
    logic              last_vld;
    region_e           last_rg;
    logic              last_we;
    logic [ADDR_W-1:0] last_addr;
    logic              b2b, reorder;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_vld  <= 1'b0;
            last_rg   <= RG_NONE;
            last_we   <= 1'b0;
            last_addr <= '0;
        end else if (fin) begin
            last_vld  <= 1'b1;
            last_rg   <= fin_rg;
            last_we   <= fin_we;
            last_addr <= fin_addr;
        end
    end

    always_comb begin
        page_hit = last_vld && last_rg == RG_FLASH && nxt_rg == RG_FLASH &&
                   last_addr[ADDR_W-1:PAGE_LSB] == nxt_addr[ADDR_W-1:PAGE_LSB];
        b2b      = last_vld && last_we && last_rg == RG_PFA &&
                   nxt_we && nxt_rg == RG_PFA;
        reorder  = order_en && last_vld && last_we && is_guarded(last_rg) &&
                   !nxt_we && is_guarded(nxt_rg) && last_addr != nxt_addr;
        pre_n    = reorder ? PRE_W'(PROT_CYC) : (b2b ? PRE_W'(1) : '0);
    end

    // R8
    order_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!order_en && nxt_rg != RG_PFA) |-> pre_n == '0);
endmodule

// File: rtl/wsbus_ctrl.sv
module wsbus_ctrl
    import wsbus_pkg::*;
#(
    parameter int PROT_CYC = 2,
    localparam int PRE_W   = $clog2(PROT_CYC + 1) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_stall,
    output logic              cpu_done,
    output logic              cpu_err,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic [CFG_W-1:0]  cfg_flash_page_ws,
    input  logic [CFG_W-1:0]  cfg_flash_rand_ws,
    input  logic [CFG_W-1:0]  cfg_otp_ws,
    input  logic              cfg_order_en,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready
);
    state_e           state;
    acc_s             cur;
    logic [WS_W-1:0]  wcnt;
    logic [PRE_W-1:0] pcnt;
    region_e          nxt_rg;
    logic             page_hit, accept, fin;
    logic [PRE_W-1:0] pre_n;
    logic [WS_W-1:0]  nxt_waits;

    assign nxt_rg = decode(cpu_addr);
    assign accept = (state == ST_IDLE) && cpu_req;

    wsbus_history #(.PROT_CYC(PROT_CYC)) u_hist (
        .clk(clk), .rst(rst),
        .fin(cpu_done), .fin_rg(cur.rg), .fin_we(cur.we), .fin_addr(cur.addr),
        .nxt_rg(nxt_rg), .nxt_we(cpu_we), .nxt_addr(cpu_addr),
        .order_en(cfg_order_en), .page_hit(page_hit), .pre_n(pre_n)
    );

    wsbus_timing u_timing (
        .rg(nxt_rg), .we(cpu_we), .page_hit(page_hit),
        .page_ws(cfg_flash_page_ws), .rand_ws(cfg_flash_rand_ws),
        .otp_ws(cfg_otp_ws), .waits(nxt_waits)
    );

    assign fin = (state == ST_ACCESS) && wcnt == '0 &&
                 (mem_ready || !is_stretchable(cur.rg));

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cur   <= '{rg: RG_NONE, we: 1'b0, addr: '0, wdata: '0};
            wcnt  <= '0;
            pcnt  <= '0;
        end else begin
            case (state)
                ST_IDLE: if (accept) begin
                    cur   <= '{rg: nxt_rg, we: cpu_we, addr: cpu_addr, wdata: cpu_wdata};
                    wcnt  <= nxt_waits;
                    pcnt  <= pre_n;
                    state <= (pre_n != '0) ? ST_ALIGN : ST_ACCESS;
                end
                ST_ALIGN: begin
                    pcnt <= pcnt - PRE_W'(1);
                    if (pcnt <= PRE_W'(1)) state <= ST_ACCESS;
                end
                ST_ACCESS: begin
                    if (wcnt != '0) wcnt <= wcnt - WS_W'(1);
                    if (fin) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        cpu_done  = fin;
        cpu_stall = (state != ST_IDLE) && !fin;
        cpu_err   = fin && cur.rg == RG_NONE;
        cpu_rdata = (fin && !cur.we && cur.rg != RG_NONE) ? mem_rdata : '0;
        mem_en    = (state == ST_ACCESS) && cur.rg != RG_NONE;
        mem_we    = mem_en && cur.we;
        mem_addr  = cur.addr;
        mem_wdata = cur.wdata;
    end

    // R10
    bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_en && !cpu_done) |=> (mem_en && $stable(mem_addr) && $stable(mem_we)));
    // R10
    quiet_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_done |=> (!mem_en && !cpu_done && !cpu_stall));
    // R9
    unmapped_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_err |-> (cpu_rdata == '0 && !mem_en));
    // R3
    fixed_frame_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_done && mem_en && !mem_ready) |-> !is_stretchable(cur.rg));
    // R11
    reset_idle_chk: assert property (@(posedge clk)
        $past(rst) |-> (!cpu_stall && !cpu_done && !mem_en));
endmodule

// File: tb/wsbus_ctrl_bench.sv
module wsbus_ctrl_bench;
    import wsbus_pkg::*;

    logic clk = 1'b0, rst = 1'b1;
    logic cpu_req = 1'b0, cpu_we = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [DATA_W-1:0] cpu_wdata = '0;
    logic cpu_stall, cpu_done, cpu_err;
    logic [DATA_W-1:0] cpu_rdata;
    logic [CFG_W-1:0] pg_ws = 4'd1, rd_ws = 4'd3, otp_ws = 4'd2;
    logic order_en = 1'b1;
    logic mem_en, mem_we, mem_ready;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata, mem_rdata;
    int hold_k = 0;
    int en_cnt = 0;
    int nchk = 0, nerr = 0;

    always #10 clk = ~clk;

    wsbus_ctrl u_wsbus_ctrl (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_stall(cpu_stall),
        .cpu_done(cpu_done), .cpu_err(cpu_err), .cpu_rdata(cpu_rdata),
        .cfg_flash_page_ws(pg_ws), .cfg_flash_rand_ws(rd_ws), .cfg_otp_ws(otp_ws),
        .cfg_order_en(order_en), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready)
    );

    always_ff @(posedge clk) en_cnt <= mem_en ? en_cnt + 1 : 0;
    assign mem_ready = (en_cnt >= hold_k);
    assign mem_rdata = mem_en ? (mem_addr[15:0] ^ 16'hA5A5) : 16'hDEAD;

    typedef struct packed {
        logic        we;
        logic [21:0] addr;
        logic [3:0]  hold;
        logic [5:0]  n;
        logic        err;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t TBL [0:23] = '{
        '{1'b0, 22'h000010, 4'd0, 6'd1,  1'b0, 4'd1},  // R1 RAM
        '{1'b0, 22'h000900, 4'd0, 6'd1,  1'b0, 4'd1},  // R1 fast frame
        '{1'b0, 22'h3F8100, 4'd0, 6'd1,  1'b0, 4'd1},  // R1 boot ROM
        '{1'b0, 22'h007004, 4'd3, 6'd3,  1'b0, 4'd3},  // R3 frame B ignores ready
        '{1'b0, 22'h006002, 4'd0, 6'd3,  1'b0, 4'd2},  // R2 frame A read
        '{1'b0, 22'h005010, 4'd5, 6'd6,  1'b0, 4'd3},  // R3 frame C stretched
        '{1'b1, 22'h006010, 4'd0, 6'd1,  1'b0, 4'd2},  // R2 frame A write
        '{1'b1, 22'h006012, 4'd0, 6'd2,  1'b0, 4'd4},  // R4 back-to-back
        '{1'b0, 22'h006020, 4'd0, 6'd5,  1'b0, 4'd8},  // R8 guard penalty
        '{1'b1, 22'h007010, 4'd0, 6'd1,  1'b0, 4'd2},  // R2 frame B write
        '{1'b0, 22'h005000, 4'd0, 6'd5,  1'b0, 4'd8},  // R8 across frames
        '{1'b0, 22'h3E0000, 4'd0, 6'd4,  1'b0, 4'd5},  // R5 random
        '{1'b0, 22'h3E0005, 4'd0, 6'd2,  1'b0, 4'd5},  // R5 paged
        '{1'b0, 22'h3E0008, 4'd0, 6'd4,  1'b0, 4'd5},  // R5 new page
        '{1'b0, 22'h3D7900, 4'd0, 6'd3,  1'b0, 4'd7},  // R7 OTP
        '{1'b0, 22'h3F7FF9, 4'd0, 6'd17, 1'b0, 4'd7},  // R7 password
        '{1'b0, 22'h200000, 4'd0, 6'd1,  1'b1, 4'd9},  // R9 unmapped read
        '{1'b1, 22'h006000, 4'd0, 6'd1,  1'b0, 4'd2},  // R2
        '{1'b0, 22'h006000, 4'd0, 6'd3,  1'b0, 4'd8},  // R8 same address
        '{1'b1, 22'h000020, 4'd0, 6'd1,  1'b0, 4'd4},  // R4 RAM writes
        '{1'b1, 22'h000022, 4'd0, 6'd1,  1'b0, 4'd4},  // R4
        '{1'b1, 22'h005004, 4'd2, 6'd3,  1'b0, 4'd3},  // R3 stretched write
        '{1'b1, 22'h005006, 4'd0, 6'd1,  1'b0, 4'd4},  // R4 frame C no gap
        '{1'b1, 22'h200010, 4'd0, 6'd1,  1'b1, 4'd9}   // R9 unmapped write
    };

    task automatic chk(input bit ok, input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL R%0d %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [21:0] a, input int hold,
                          input int exp_n, input logic exp_err, input int req,
                          input bit scramble);
        int n = 0;
        bit bad_bus = 0;
        bit stall_ok = 1;
        logic err = 1'b0;
        logic [15:0] rd = '0;
        logic [15:0] exp_rd;
        @(negedge clk);
        hold_k = hold; cpu_we = we; cpu_addr = a; cpu_wdata = a[15:0] + 16'h1111;
        cpu_req = 1'b1;
        @(negedge clk);
        if (scramble) begin cpu_addr = 22'h000000; cpu_we = ~we; end
        else cpu_req = 1'b0;
        for (int i = 0; i < 40; i++) begin
            n++;
            if (mem_en && (mem_addr != a || mem_we != we ||
                           (we && mem_wdata != a[15:0] + 16'h1111))) bad_bus = 1;
            if (cpu_done) begin err = cpu_err; rd = cpu_rdata; break; end
            if (!cpu_stall) stall_ok = 0;
            @(negedge clk);
        end
        cpu_req = 1'b0;
        exp_rd = (we || exp_err) ? 16'h0 : (a[15:0] ^ 16'hA5A5);
        chk(n == exp_n, req, $sformatf("cycles @%0h", a), n, exp_n);
        chk(err == exp_err, req, $sformatf("err @%0h", a), err, exp_err);
        chk(rd == exp_rd, req, $sformatf("rdata @%0h", a), rd, exp_rd);
        chk(!bad_bus && stall_ok, 10, $sformatf("bus/stall @%0h", a), {bad_bus, stall_ok}, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++; nchk++;
        $display("FAIL R10 watchdog expired: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(!cpu_stall && !cpu_done && !mem_en, 11, "reset outputs",
            {cpu_stall, cpu_done, mem_en}, 0);
        rst = 1'b0;

        for (int i = 0; i < 24; i++)
            access(TBL[i].we, TBL[i].addr, int'(TBL[i].hold), int'(TBL[i].n),
                   TBL[i].err, int'(TBL[i].req), 1'b0);

        // R6 clamping to floors
        pg_ws = 4'd0; rd_ws = 4'd0; otp_ws = 4'd0;
        access(1'b0, 22'h3E1000, 0, 2, 1'b0, 6, 1'b0);
        access(1'b0, 22'h3E1001, 0, 1, 1'b0, 6, 1'b0);
        access(1'b0, 22'h3D7800, 0, 2, 1'b0, 6, 1'b0);
        pg_ws = 4'd5; rd_ws = 4'd2;
        access(1'b0, 22'h3E2000, 0, 6, 1'b0, 6, 1'b0);
        pg_ws = 4'd1; rd_ws = 4'd3; otp_ws = 4'd2;

        // R8 guard disabled
        order_en = 1'b0;
        access(1'b1, 22'h006100, 0, 1, 1'b0, 8, 1'b0);
        access(1'b0, 22'h006102, 0, 3, 1'b0, 8, 1'b0);
        order_en = 1'b1;

        // R10 request inputs change while busy: no effect
        access(1'b0, 22'h3F7FFA, 0, 17, 1'b0, 10, 1'b1);

        // R11 reset mid-access and history cleared
        access(1'b1, 22'h006200, 0, 1, 1'b0, 11, 1'b0);
        @(negedge clk);
        cpu_we = 1'b0; cpu_addr = 22'h3F7FF8; cpu_req = 1'b1;
        @(negedge clk); cpu_req = 1'b0;
        repeat (3) @(negedge clk);
        chk(cpu_stall, 10, "stall during password read", cpu_stall, 1);
        rst = 1'b1;
        @(negedge clk);
        chk(!cpu_stall && !mem_en && !cpu_done, 11, "reset aborts access",
            {cpu_stall, mem_en, cpu_done}, 0);
        rst = 1'b0;
        access(1'b1, 22'h006202, 0, 1, 1'b0, 11, 1'b0);
        access(1'b1, 22'h006204, 0, 2, 1'b0, 4, 1'b0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule